// File: doc/BRIEF.md
# SPI Master with Transmit and Receive FIFOs

This block is a serial peripheral interface master that runs entirely from its FIFOs. A host pushes 32-bit words into an 8-entry transmit FIFO and pops 32-bit words from an 8-entry receive FIFO through simple write and read strobes. There is no start bit to set. Whenever the serial engine is idle and the transmit FIFO holds a word, the engine takes that word and shifts it out MSB first, and it captures 32 bits from MISO at the same time. Each completed received word is pushed into the receive FIFO.

After every word the engine holds a programmable suspend gap, with the clock idle and chip select still low. If more data is waiting when the gap ends, the next word follows with chip select kept low. Otherwise chip select is released and the engine goes idle. Each FIFO has a programmable level comparison that drives an interrupt output. A sticky overrun flag records any received word that was lost because the receive FIFO was full.

Top module: `spi_fifo_master`

## Requirements
- R1: Words leave on MOSI in the order they were written, and words read from `rd_data` come out in the order they were received. Each FIFO holds 8 words of 32 bits.
- R2: `tx_irq` is 1 exactly when `tx_count` is less than or equal to `tx_thresh`.
- R3: `rx_irq` is 1 exactly when `rx_count` is strictly greater than `rx_thresh`.
- R4: Each empty flag is 1 exactly when its count is 0, and each full flag is 1 exactly when its count is 8. A write while the transmit FIFO is full is ignored. A read while the receive FIFO is empty is ignored. After reset both FIFOs are empty.
- R5: At the first clock edge at which the engine is idle and the transmit FIFO is non-empty, the engine pops one word. From the next cycle `busy` is 1 and `cs_n` is 0.
- R6: A word takes 64 half-periods of SCLK. After the 32nd falling SCLK edge, a suspend gap of (`suspend_cfg`+2) SCLK periods follows, which is 2·(`suspend_cfg`+2)·(`clk_div`+1) system cycles. During the gap SCLK is low and `cs_n` stays 0.
- R7: At the end of a gap the engine pops the next word at once if the transmit FIFO is non-empty. Otherwise it raises `cs_n` and drops `busy`.
- R8: SPI mode 0 is used. SCLK idles low and each half-period lasts `clk_div`+1 system cycles. MOSI changes only on falling edges and presents bit 31 before the first rising edge.
- R9: MISO is sampled at each rising SCLK edge, MSB first. The assembled word is pushed into the receive FIFO at the 32nd falling edge.
- R10: A received word that completes while the receive FIFO holds 8 entries is dropped and sets `rx_overrun`. The flag stays set until a cycle with `ovr_clr` high, and a new drop in that same cycle takes priority over the clear.
- R11: `tx_count` and `rx_count` are 4-bit occupancy counts, range 0 to 8, that are updated one cycle after the accepted push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push `wr_data` into the transmit FIFO |
| wr_data | input | 32 | Word to transmit |
| rd_en | input | 1 | Pop the head of the receive FIFO |
| rd_data | output | 32 | Head of the receive FIFO (show-ahead) |
| tx_thresh | input | 3 | Transmit level threshold |
| rx_thresh | input | 3 | Receive level threshold |
| clk_div | input | 8 | SCLK half-period minus one, in system cycles |
| suspend_cfg | input | 4 | Suspend gap setting; gap is this plus 2 SCLK periods |
| ovr_clr | input | 1 | Clears the overrun flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Engine in a word or a gap |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| tx_count | output | 4 | Transmit FIFO occupancy |
| rx_count | output | 4 | Receive FIFO occupancy |
| tx_irq | output | 1 | Transmit level flag |
| rx_irq | output | 1 | Receive level flag |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The gap and half-period assertions assume that `clk_div` and `suspend_cfg` stay constant while `busy` is 1. A change in the middle of a word would make the cycle count of that word depend on when the change happened. The stimulus therefore changes these two settings only after it has waited for the engine to go idle with the transmit FIFO empty. Thresholds may change at any time because the level flags are combinational from the counts. All inputs are driven one time unit after the falling clock edge, so every sampled value is settled before the next rising edge.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_XFER = 2'd1,
    ENG_GAP  = 2'd2
  } eng_state_t;

  // transmit level flag: occupancy at or below the threshold
  function automatic logic tx_level_hit(input logic [7:0] cnt, input logic [7:0] th);
    return cnt <= th;
  endfunction

  // receive level flag: occupancy strictly above the threshold
  function automatic logic rx_level_hit(input logic [7:0] cnt, input logic [7:0] th);
    return cnt > th;
  endfunction

  // number of SCLK half-periods in the suspend gap
  function automatic logic [5:0] gap_halves(input logic [3:0] sus);
    return ({2'b00, sus} + 6'd2) << 1;
  endfunction

endpackage

// File: rtl/sync_fifo.sv
module sync_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R4
  fifo_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (count == $past(count) + 1'b1));

  // R4
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spi_fifo_pkg::*;
#(
  parameter int W     = 32,
  parameter int DIV_W = 8,
  localparam int EW   = $clog2(2 * W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic [3:0]       sus,
  input  logic             tx_avail,
  input  logic [W-1:0]     tx_word,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [W-1:0]     rx_word,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic             busy
);

  eng_state_t       state;
  logic [DIV_W-1:0] div_cnt;
  logic [EW-1:0]    edge_cnt;
  logic [5:0]       gap_cnt;
  logic [W-1:0]     tx_sh, rx_sh;
  logic             sclk_q;

  // named internal events
  logic half_tick, gap_end, word_end, start;

  assign half_tick = (div_cnt == div);
  assign gap_end   = (state == ENG_GAP) && half_tick && (gap_cnt == 6'(gap_halves(sus) - 6'd1));
  assign word_end  = (state == ENG_XFER) && half_tick && sclk_q && (edge_cnt == EW'(2 * W - 1));
  assign start     = tx_avail && ((state == ENG_IDLE) || gap_end);

  assign tx_pop  = start;
  assign rx_push = word_end;
  assign rx_word = rx_sh;
  assign sclk    = sclk_q;
  assign mosi    = tx_sh[W-1];
  assign cs_n    = (state == ENG_IDLE);
  assign busy    = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      div_cnt  <= '0;
      edge_cnt <= '0;
      gap_cnt  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      sclk_q   <= 1'b0;
    end else begin
      if (start) begin
        tx_sh    <= tx_word;
        state    <= ENG_XFER;
        div_cnt  <= '0;
        edge_cnt <= '0;
      end else begin
        case (state)
          ENG_XFER: begin
            if (half_tick) begin
              div_cnt  <= '0;
              sclk_q   <= ~sclk_q;
              edge_cnt <= edge_cnt + 1'b1;
              if (!sclk_q) begin
                rx_sh <= {rx_sh[W-2:0], miso};
              end else if (word_end) begin
                state   <= ENG_GAP;
                gap_cnt <= '0;
              end else begin
                tx_sh <= tx_sh << 1;
              end
            end else begin
              div_cnt <= div_cnt + 1'b1;
            end
          end
          ENG_GAP: begin
            if (half_tick) begin
              div_cnt <= '0;
              gap_cnt <= gap_cnt + 1'b1;
              if (gap_end) state <= ENG_IDLE;
            end else begin
              div_cnt <= div_cnt + 1'b1;
            end
          end
          default: div_cnt <= '0;
        endcase
      end
    end
  end

  // R5
  start_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !cs_n);

  // R6
  gap_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_GAP) |-> !sclk);

  // R7
  release_from_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(state == ENG_GAP));

  // R8
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ENG_XFER) && !half_tick) |=> $stable(sclk));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int DIV_W   = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int TH_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [TH_W-1:0]   tx_thresh,
  input  logic [TH_W-1:0]   rx_thresh,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [3:0]        suspend_cfg,
  input  logic              ovr_clr,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic              busy,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              rx_empty,
  output logic              rx_full,
  output logic [CNT_W-1:0]  tx_count,
  output logic [CNT_W-1:0]  rx_count,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              rx_overrun
);

  logic [DATA_W-1:0] tx_head, rx_word;
  logic              tx_pop, rx_push, rx_drop, ovr_q;

  sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(tx_pop),
    .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word), .pop(rd_en),
    .head(rd_data), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  spi_word_engine #(.W(DATA_W), .DIV_W(DIV_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .div(clk_div), .sus(suspend_cfg),
    .tx_avail(!tx_empty), .tx_word(tx_head), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy)
  );

  assign rx_drop = rx_push & rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (rx_drop) ovr_q <= 1'b1;
    else if (ovr_clr) ovr_q <= 1'b0;
  end

  assign rx_overrun = ovr_q;
  assign tx_irq = tx_level_hit(8'(tx_count), 8'(tx_thresh));
  assign rx_irq = rx_level_hit(8'(rx_count), 8'(rx_thresh));

  // R10
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> rx_overrun);

  // R10
  ovr_drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !rd_en) |=> rx_full);

endmodule

// File: tb/spi_fifo_master_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_master_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [2:0]  tx_thresh = 3'd0, rx_thresh = 3'd0;
  logic [7:0]  clk_div = 8'd1;
  logic [3:0]  suspend_cfg = 4'd0;
  logic        sclk, mosi, miso, cs_n, busy;
  logic        tx_empty, tx_full, rx_empty, rx_full, tx_irq, rx_irq, rx_overrun;
  logic [3:0]  tx_count, rx_count;

  always #2.5 clk = ~clk;

  spi_fifo_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .clk_div(clk_div), .suspend_cfg(suspend_cfg), .ovr_clr(ovr_clr),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
    .tx_count(tx_count), .rx_count(rx_count), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .rx_overrun(rx_overrun)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] slave_val(input int k);
    return 32'hC3A5_0001 ^ (32'(k) * 32'h0001_0F1D);
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [31:0] q_tx[$], q_rx[$], q_sent[$];
  int  m_state = 0, m_tmr = 0, m_k = 0;
  bit  m_ovr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_tx.delete(); q_rx.delete(); q_sent.delete();
      m_state = 0; m_tmr = 0; m_k = 0; m_ovr = 0;
    end else begin
      int pre_tx, pre_rx, d, s;
      bit set_ovr;
      pre_tx = q_tx.size(); pre_rx = q_rx.size();
      d = int'(clk_div) + 1; s = int'(suspend_cfg);
      set_ovr = 0;
      case (m_state)
        0: if (pre_tx > 0) begin
             q_sent.push_back(q_tx.pop_front()); m_state = 1; m_tmr = 64 * d;
           end
        1: begin
             m_tmr--;
             if (m_tmr == 0) begin
               if (pre_rx < 8) q_rx.push_back(slave_val(m_k));
               else set_ovr = 1;
               m_k++;
               m_state = 2; m_tmr = 2 * (s + 2) * d;
             end
           end
        default: begin
             m_tmr--;
             if (m_tmr == 0) begin
               if (pre_tx > 0) begin
                 q_sent.push_back(q_tx.pop_front()); m_state = 1; m_tmr = 64 * d;
               end else m_state = 0;
             end
           end
      endcase
      if (wr_en && pre_tx < 8) q_tx.push_back(wr_data);
      if (rd_en && pre_rx > 0) void'(q_rx.pop_front());
      if (set_ovr) m_ovr = 1;
      else if (ovr_clr) m_ovr = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(tx_count == 4'(q_tx.size()), "R11 tx_count", 32'(tx_count), 32'(q_tx.size()));
      chk(rx_count == 4'(q_rx.size()), "R11 rx_count", 32'(rx_count), 32'(q_rx.size()));
      chk(tx_empty == (q_tx.size() == 0), "R4 tx_empty", 32'(tx_empty), 32'(q_tx.size() == 0));
      chk(tx_full  == (q_tx.size() == 8), "R4 tx_full",  32'(tx_full),  32'(q_tx.size() == 8));
      chk(rx_empty == (q_rx.size() == 0), "R4 rx_empty", 32'(rx_empty), 32'(q_rx.size() == 0));
      chk(rx_full  == (q_rx.size() == 8), "R4 rx_full",  32'(rx_full),  32'(q_rx.size() == 8));
      chk(tx_irq == (q_tx.size() <= int'(tx_thresh)), "R2 tx_irq", 32'(tx_irq), 32'(q_tx.size() <= int'(tx_thresh)));
      chk(rx_irq == (q_rx.size() >  int'(rx_thresh)), "R3 rx_irq", 32'(rx_irq), 32'(q_rx.size() > int'(rx_thresh)));
      chk(busy == (m_state != 0), "R5 busy", 32'(busy), 32'(m_state != 0));
      chk(cs_n == (m_state == 0), "R7 cs_n", 32'(cs_n), 32'(m_state == 0));
      if (m_state != 1) chk(sclk == 1'b0, "R6 sclk idle", 32'(sclk), 32'd0);
      chk(rx_overrun == m_ovr, "R10 rx_overrun", 32'(rx_overrun), 32'(m_ovr));
      if (q_rx.size() > 0) chk(rd_data == q_rx[0], "R9 rd_data head", rd_data, q_rx[0]);
    end
  end

  // ---------------- serial slave and MOSI capture ----------------
  logic [31:0] slave_sh;
  logic [31:0] cap_sh = '0;
  int  sk = 0, n_fall = 0, n_rise = 0;
  bit  prev_sclk = 0;
  assign miso = slave_sh[31];

  initial slave_sh = slave_val(0);

  always @(negedge clk) begin
    if (!rst_n) begin
      sk = 0; n_fall = 0; n_rise = 0; prev_sclk = 0; slave_sh = slave_val(0);
    end else begin
      if (sclk && !prev_sclk) begin
        cap_sh = {cap_sh[30:0], mosi};
        n_rise++;
        if (n_rise == 32) begin
          n_rise = 0;
          if (q_sent.size() > 0) begin
            logic [31:0] exp_w;
            exp_w = q_sent.pop_front();
            chk(cap_sh == exp_w, "R8/R1 MOSI word", cap_sh, exp_w);
          end else chk(1'b0, "R1 MOSI word without pop", cap_sh, 32'd0);
        end
      end
      if (!sclk && prev_sclk) begin
        n_fall++;
        if (n_fall == 32) begin
          n_fall = 0; sk++; slave_sh = slave_val(sk);
        end else slave_sh = slave_sh << 1;
      end
      prev_sclk = sclk;
    end
  end

  // ---------------- stimulus ----------------
  task automatic write_burst(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_data = base + 32'(i) * 32'h1357_2468;
      @(negedge clk); #1;
    end
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || !tx_empty);
    #1;
  endtask

  task automatic drain_rx();
    while (!rx_empty) begin
      rd_en = 1'b1; @(negedge clk); #1;
    end
    rd_en = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      chk(1'b0, "watchdog expired", 32'(cyc), 32'd150000);
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R4 reset flags", {tx_empty, rx_empty, tx_full, rx_full}, 32'hC);
    chk(cs_n && !busy && !sclk, "R5 reset idle", {cs_n, busy, sclk}, 32'h4);
    #1;

    // phase A: short burst, clk_div 1, gap setting 0
    clk_div = 8'd1; suspend_cfg = 4'd0; tx_thresh = 3'd2; rx_thresh = 3'd3;
    write_burst(3, 32'h8000_0001);
    wait_idle();
    chk(rx_count == 4'd3, "R9 three words received", 32'(rx_count), 32'd3);
    chk(rx_irq == 1'b0, "R3 count equal to threshold", 32'(rx_irq), 32'd0);
    chk(tx_irq == 1'b1, "R2 empty fifo at or below", 32'(tx_irq), 32'd1);
    drain_rx();

    // phase B: overfill both FIFOs, fastest clock, gap setting 3
    clk_div = 8'd0; suspend_cfg = 4'd3; tx_thresh = 3'd7; rx_thresh = 3'd6;
    write_burst(12, 32'h0F0F_1234);
    chk(tx_full == 1'b1, "R4 tx full after overfill", 32'(tx_full), 32'd1);
    chk(tx_count == 4'd8, "R4 extra writes ignored", 32'(tx_count), 32'd8);
    wait_idle();
    chk(rx_full && rx_irq, "R3 full rx above threshold", {rx_full, rx_irq}, 32'h3);
    chk(rx_overrun == 1'b1, "R10 overrun set", 32'(rx_overrun), 32'd1);
    repeat (3) @(negedge clk);
    #1;
    chk(rx_overrun == 1'b1, "R10 overrun sticky", 32'(rx_overrun), 32'd1);
    ovr_clr = 1'b1; @(negedge clk); #1; ovr_clr = 1'b0;
    chk(rx_overrun == 1'b0, "R10 overrun cleared", 32'(rx_overrun), 32'd0);
    drain_rx();
    rd_en = 1'b1; @(negedge clk); #1; rd_en = 1'b0;
    chk(rx_count == 4'd0 && rx_empty, "R4 read of empty ignored", 32'(rx_count), 32'd0);

    // phase C: trickle writes during words and gaps, slow clock, longest gap
    clk_div = 8'd2; suspend_cfg = 4'd15; tx_thresh = 3'd1; rx_thresh = 3'd0;
    for (int i = 0; i < 5; i++) begin
      write_burst(1, 32'hA000_0000 + 32'(i));
      repeat (120 + i * 97) @(negedge clk);
      #1;
    end
    wait_idle();
    chk(cs_n == 1'b1, "R7 released after drain", 32'(cs_n), 32'd1);
    drain_rx();

    // phase D: zero thresholds
    clk_div = 8'd3; suspend_cfg = 4'd1; tx_thresh = 3'd0; rx_thresh = 3'd0;
    write_burst(2, 32'h5555_AAAA);
    chk(tx_irq == 1'b0, "R2 one word above zero threshold", 32'(tx_irq), 32'd0);
    wait_idle();
    chk(rx_irq == 1'b1, "R3 rx above zero threshold", 32'(rx_irq), 32'd1);
    drain_rx();
    repeat (4) @(negedge clk);
    summary();
  end

endmodule